// File: doc/BRIEF.md
# Saturating Counter Noise Filter

This block cleans up one asynchronous serial receive line before a receiver sees it. The raw line first passes through a two-stage synchronizer. The synchronized sample then steers a saturating up/down counter. The counter steps up on a high sample and down on a low one. Narrow glitches only move the counter part of the way and are therefore absorbed.

The top end of the counter's range comes from a prescale configuration field. The field is shifted right by three bits and OR-ed with 0x0F, so the range is never shorter than 15. A hysteresis latch drives the filtered output. It goes high when the counter lands on the top end and low when the counter lands on zero. Between those two points it holds its value.

The prescale field is a plain static input and is normally left unchanged during traffic. If it is lowered while the counter sits above the new top end, the counter is pulled down to that end.

Top module: `noise_filter`

## Requirements
- R1: While rst_ni is low, the counter, both synchronizer stages and rx_filt_o are all 0. After release, rx_filt_o stays 0 until the full upper end point of high samples has been counted.
- R2: rx_raw_i passes through two flip-flop stages before it reaches the counter. A change on the pin therefore affects the counter only from the third rising edge after the change.
- R3: On each rising edge the counter steps up by one if the synchronized sample is 1, and down by one if it is 0. It saturates at zero and at the upper end point, so it never wraps.
- R4: The upper end point is (presc_i >> 3) | 0x0F. presc_i = 0 gives 15, presc_i = 0x178 gives 0x2F, and presc_i = 0x3FF gives 0x7F.
- R5: rx_filt_o becomes 1 on the same edge where the counter reaches the upper end point. It becomes 0 on the same edge where the counter reaches zero.
- R6: While the counter lies strictly between its end points, rx_filt_o holds its value. A high burst shorter than the end point in samples, starting from the low saturated state, leaves rx_filt_o at 0.
- R7: From the low saturated state, a sustained high on rx_raw_i raises rx_filt_o exactly end point + 2 rising edges after the first edge that samples the high. From the high saturated state, a sustained low lowers it with the same timing.
- R8: If presc_i changes so that the counter exceeds the new end point, the next edge loads the counter with the new end point and sets rx_filt_o to 1.
- R9: Extra high samples taken while the counter is saturated high are not banked. A later low run still needs exactly end point samples to clear the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Filter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_raw_i | input | 1 | Raw asynchronous receive line |
| presc_i | input | PRESC_W (10) | Prescale field that sets the upper end point |
| rx_filt_o | output | 1 | Filtered receive data |

## Verification
The assertions check the following on every cycle:
- the counter never exceeds a stable end point;
- the counter moves by at most one step except on a clamp;
- the output is 0 whenever the counter is at zero;
- the output is 1 whenever the counter sits on a stable end point;
- the output only falls at zero.

Only the bench's scenarios can show the rest. These are the exact end point + 2 latency through the synchronizer, the end point values for particular prescale codes, and the rejection of short bursts. They also include the clamp response to a prescale change and the absence of banking while saturated. The bench shows these against a behavioural model compared on every clock.

// File: rtl/nf_pkg.sv
package nf_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_UP    = 2'd1,
    CNT_DN    = 2'd2,
    CNT_CLAMP = 2'd3
  } cnt_op_e;

  localparam int unsigned END_SHIFT = 3;
  localparam int unsigned END_FLOOR = 15;
endpackage

// File: rtl/nf_sync.sv
module nf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= {stage_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/nf_endpoint.sv
module nf_endpoint #(
  parameter int unsigned PRESC_W = 10,
  parameter int unsigned CNT_W   = 7
) (
  input  logic [PRESC_W-1:0] presc_i,
  output logic [CNT_W-1:0]   end_o
);
  import nf_pkg::*;

  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(END_FLOOR);

  logic [PRESC_W-1:0] shifted;

  assign shifted = presc_i >> END_SHIFT;
  assign end_o   = CNT_W'(shifted) | FLOOR;
endmodule

// File: rtl/nf_counter.sv
module nf_counter #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic [CNT_W-1:0] end_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  import nf_pkg::*;

  cnt_op_e          op;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q > end_i)                      op = CNT_CLAMP;
    else if (sample_i && cnt_q != end_i)    op = CNT_UP;
    else if (!sample_i && cnt_q != '0)      op = CNT_DN;
    else                                    op = CNT_HOLD;
  end

  always_comb begin
    unique case (op)
      CNT_UP:    cnt_d = cnt_q + 1'b1;
      CNT_DN:    cnt_d = cnt_q - 1'b1;
      CNT_CLAMP: cnt_d = end_i;
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
endmodule

// File: rtl/nf_latch.sv
module nf_latch #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] end_i,
  output logic             q_o
);
  logic set_hit, clr_hit, q_q;

  // decide on the next count so the output moves on the same edge as the counter
  assign set_hit = (cnt_nxt_i == end_i);
  assign clr_hit = (cnt_nxt_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= 1'b0;
    else if (set_hit) q_q <= 1'b1;
    else if (clr_hit) q_q <= 1'b0;
  end

  assign q_o = q_q;
endmodule

// File: rtl/noise_filter.sv
module noise_filter #(
  parameter int unsigned PRESC_W     = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_raw_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               rx_filt_o
);
  localparam int unsigned SHIFTED_W = PRESC_W - 3;
  localparam int unsigned CNT_W     = (SHIFTED_W > 4) ? SHIFTED_W : 4;

  logic             rx_sync;
  logic [CNT_W-1:0] end_pt, cnt_q, cnt_nxt;

  nf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_raw_i),
    .q_o   (rx_sync)
  );

  nf_endpoint #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_end (
    .presc_i(presc_i),
    .end_o  (end_pt)
  );

  nf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (rx_sync),
    .end_i    (end_pt),
    .cnt_o    (cnt_q),
    .cnt_nxt_o(cnt_nxt)
  );

  nf_latch #(.CNT_W(CNT_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_nxt_i(cnt_nxt),
    .end_i    (end_pt),
    .q_o      (rx_filt_o)
  );
endmodule

// File: rtl/noise_filter_chk.sv
module noise_filter_chk #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] end_pt,
  input logic             rx_filt_o
);
  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(end_pt) |-> (cnt_q <= end_pt));

  // R3
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_q) <= $past(end_pt)) |->
      ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) ||
       ($past(cnt_q) == cnt_q + 1'b1)));

  // R5
  zero_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> !rx_filt_o);

  // R5
  top_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q == end_pt) && $stable(end_pt)) |-> rx_filt_o);

  // R6
  fall_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_filt_o) |-> (cnt_q == '0));

  // R8
  clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > end_pt) |=> (rx_filt_o && (cnt_q == $past(end_pt))));
endmodule

bind noise_filter noise_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_q    (cnt_q),
  .end_pt   (end_pt),
  .rx_filt_o(rx_filt_o)
);

// File: tb/tb_noise_filter.sv
module tb_noise_filter;
  localparam int PW = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rx_raw_i = 1'b0;
  logic [PW-1:0] presc_i = '0;
  logic          rx_filt_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt = 0;
  int m_out = 0;
  int m_s1 = 0;
  int m_s2 = 0;

  always #5 clk_i = ~clk_i;

  noise_filter #(.PRESC_W(PW)) dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_raw_i (rx_raw_i),
    .presc_i  (presc_i),
    .rx_filt_o(rx_filt_o)
  );

  function automatic int endp(input int p);
    return (p >> 3) | 15;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_out = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      int e;
      e = endp(int'(presc_i));
      if (m_cnt > e)                  m_cnt = e;
      else if (m_s2 != 0 && m_cnt < e) m_cnt = m_cnt + 1;
      else if (m_s2 == 0 && m_cnt > 0) m_cnt = m_cnt - 1;
      if (m_cnt == e)      m_out = 1;
      else if (m_cnt == 0) m_out = 0;
      m_s2 = m_s1;
      m_s1 = int'(rx_raw_i);
    end
  end

  // R3 R5 lockstep comparison against the model, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      n_vec++;
      if (int'(rx_filt_o) != m_out) begin
        n_bad++;
        $display("FAIL R3/R5 lockstep t=%0t act=%0d exp=%0d", $time, rx_filt_o, m_out);
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // drive a level at a falling edge, count rising edges until output reaches want
  task automatic edges_to(input logic lvl, input logic want, output int n);
    rx_raw_i = lvl;
    n = 0;
    while (rx_filt_o !== want && n < 400) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    int e;
    @(negedge clk_i);
    chk("R1 output during reset", rx_filt_o, 1'b0);
    rx_raw_i = 1'b1;
    cycles(2);
    chk("R1 reset holds output low with high input", rx_filt_o, 1'b0);
    rst_ni = 1'b1;
    rx_raw_i = 1'b0;
    cycles(3);
    chk("R1 output after release", rx_filt_o, 1'b0);

    // R7 R2 rise latency, end point 15
    presc_i = '0;
    e = endp(0);
    edges_to(1'b1, 1'b1, n);
    chk_int("R7 rise latency end 15", n, e + 2);

    // R9 saturated high, extra samples not banked
    cycles(20);
    edges_to(1'b0, 1'b0, n);
    chk_int("R9 fall latency after long high", n, e + 2);

    // R6 burst of e-1 samples ignored
    cycles(5);
    rx_raw_i = 1'b1;
    cycles(e - 1);
    rx_raw_i = 1'b0;
    for (int i = 0; i < 3 * e; i++) begin
      @(negedge clk_i);
      if (rx_filt_o !== 1'b0) begin
        chk("R6 short burst ignored", rx_filt_o, 1'b0);
        break;
      end
    end
    chk("R6 output after short burst", rx_filt_o, 1'b0);

    // R6 burst of exactly e samples does change it
    rx_raw_i = 1'b1;
    cycles(e);
    rx_raw_i = 1'b0;
    cycles(3);
    chk("R6 burst of end point samples sets output", rx_filt_o, 1'b1);
    edges_to(1'b0, 1'b0, n);
    cycles(5);

    // R4 end point 0x2F
    presc_i = 10'h178;
    chk_int("R4 end point formula 0x178", endp(10'h178), 8'h2F);
    edges_to(1'b1, 1'b1, n);
    chk_int("R4 rise latency end 0x2F", n, 8'h2F + 2);
    edges_to(1'b0, 1'b0, n);
    chk_int("R7 fall latency end 0x2F", n, 8'h2F + 2);

    // R4 widest end point 0x7F
    presc_i = 10'h3FF;
    edges_to(1'b1, 1'b1, n);
    chk_int("R4 rise latency end 0x7F", n, 8'h7F + 2);
    edges_to(1'b0, 1'b0, n);
    chk_int("R7 fall latency end 0x7F", n, 8'h7F + 2);

    // R8 clamp on prescale reduction
    rx_raw_i = 1'b1;
    cycles(60);
    chk("R8 midway before clamp", rx_filt_o, 1'b0);
    presc_i = '0;
    @(negedge clk_i);
    chk("R8 clamp sets output", rx_filt_o, 1'b1);
    edges_to(1'b0, 1'b0, n);
    chk_int("R8 fall latency after clamp", n, 15 + 2);

    // R3 noisy traffic, lockstep only
    presc_i = 10'h080;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      if (($urandom % 8) == 0) rx_raw_i = ~rx_raw_i;
    end
    rx_raw_i = 1'b0;
    cycles(200);
    chk("R3 settles low after noise", rx_filt_o, 1'b0);

    // R1 asynchronous reset mid-count
    rx_raw_i = 1'b1;
    cycles(10);
    #2 rst_ni = 1'b0;
    #1;
    chk("R1 async reset clears output", rx_filt_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    presc_i = '0;
    edges_to(1'b1, 1'b1, n);
    chk_int("R1 full count needed after reset", n, 15 + 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule